// File: doc/BRIEF.md
# Vector Lane Bitfield Extract/Insert Unit

This unit performs one bitfield operation per request on the low 64-bit lane of two 128-bit vector operands. In extract mode it takes a field of a chosen length and starting bit out of the first operand and returns it right-justified, with zeros above it. In insert mode it takes the low bits of the second operand and writes them into the first operand at a chosen starting bit, leaving every other bit of the first operand as it was.

The field length and starting bit come either from two immediate bytes presented with the request, or from fixed bit ranges inside the second operand. Which ranges are used depends on the operation. The result, with its upper 64 bits forced to zero, is registered and appears together with a valid flag one clock after the request. A new request may be issued on every clock.

Top module: `bfx_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_valid` and all of `res_data` become 0 at that edge.
- R2: `res_valid` is high in the cycle after a cycle with `req_valid` high and low in the cycle after a cycle with `req_valid` low. Requests may be issued back to back, and each one yields its own result in order.
- R3: Extract (`op_insert`=0): for field length N and start P, result bit i equals `opa[i+P]` when i < N and i+P < 64. Every other bit of the low 64 is 0.
- R4: Insert (`op_insert`=1): for field length N and start P, result bit i equals `opb[i-P]` when P <= i < P+N and i < 64. Every other bit of the low 64 equals `opa[i]`.
- R5: Only bits [5:0] of a length code and of a start code are used. A length code of 0 means N = 64.
- R6: Register-form extract (`use_reg`=1, `op_insert`=0) takes the length code from `opb[5:0]` and the start code from `opb[13:8]`. The immediates are ignored.
- R7: Register-form insert (`use_reg`=1, `op_insert`=1) takes the length code from `opb[69:64]` and the start code from `opb[77:72]`. The immediates are ignored.
- R8: Immediate form (`use_reg`=0) takes the length code from `imm_len` and the start code from `imm_pos`.
- R9: `res_data[127:64]` is always 0. Bits [127:64] of `opa`, and bits of `opb` outside the used ranges, never affect the result.
- R10: An insert field that runs past bit 63 is truncated: the bits that would land above bit 63 are dropped.
- R11: While no request is issued, `res_data` keeps the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| op_insert | input | 1 | 0 = extract, 1 = insert |
| use_reg | input | 1 | 0 = controls from immediates, 1 = controls from `opb` |
| imm_len | input | 8 | Immediate length code (bits [5:0] used) |
| imm_pos | input | 8 | Immediate start-bit code (bits [5:0] used) |
| opa | input | 128 | First operand: field source for extract, destination for insert |
| opb | input | 128 | Second operand: insert data in its low bits, control fields for the register form |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_data | output | 128 | Result: low 64 bits computed, upper 64 bits zero |

## Verification
The bound checker tests the properties that hold on every cycle:
- the reset state;
- the one-clock relation between `req_valid` and `res_valid`;
- the all-zero upper half of the result;
- that `res_data` holds its value while the unit is idle;
- the zero fill of an extract with a one-bit field.

The field arithmetic can only be shown by the bench's scenarios, which compare each result against a bit-by-bit model. These scenarios cover the placement of the field in both operations, the length code of zero, the ignored high bits of the codes, the two register-form control layouts, truncation past bit 63, and back-to-back traffic.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  parameter int LANE_W = 64;
  parameter int VEC_W  = 128;
  parameter int CODE_W = $clog2(LANE_W);
  parameter int LEN_W  = CODE_W + 1;

  typedef enum logic {
    BFX_EXTRACT = 1'b0,
    BFX_INSERT  = 1'b1
  } bfx_op_e;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [CODE_W-1:0] pos;
  } bfx_ctl_t;
endpackage

// File: rtl/bfx_ctl_sel.sv
module bfx_ctl_sel
  import bfx_pkg::*;
#(
  parameter int VW          = VEC_W,
  parameter int LW          = LANE_W,
  parameter int CW          = CODE_W,
  parameter int IMM_W       = 8,
  parameter int EXT_LEN_LSB = 0,
  parameter int EXT_POS_LSB = 8,
  parameter int INS_LEN_LSB = 64,
  parameter int INS_POS_LSB = 72
) (
  input  bfx_op_e          op,
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm_len,
  input  logic [IMM_W-1:0] imm_pos,
  input  logic [VW-1:0]    opb,
  output bfx_ctl_t         ctl
);
  localparam int NW = CW + 1;

  logic [CW-1:0] len_code;
  logic [CW-1:0] pos_code;
  logic          unused_bits;

  always_comb begin
    if (!use_reg) begin
      len_code = imm_len[CW-1:0];
      pos_code = imm_pos[CW-1:0];
    end else if (op == BFX_INSERT) begin
      len_code = opb[INS_LEN_LSB +: CW];
      pos_code = opb[INS_POS_LSB +: CW];
    end else begin
      len_code = opb[EXT_LEN_LSB +: CW];
      pos_code = opb[EXT_POS_LSB +: CW];
    end
  end

  // a zero length code denotes a full-lane field
  assign ctl.len = (len_code == '0) ? NW'(LW) : {1'b0, len_code};
  assign ctl.pos = pos_code;

  assign unused_bits = ^{imm_len, imm_pos, opb};
endmodule

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen
  import bfx_pkg::*;
#(
  parameter int LW = LANE_W,
  parameter int CW = CODE_W
) (
  input  bfx_ctl_t      ctl,
  output logic [LW-1:0] low_mask,
  output logic [LW-1:0] fld_mask
);
  localparam int NW = CW + 1;

  for (genvar i = 0; i < LW; i++) begin : g_thermo
    assign low_mask[i] = (ctl.len > NW'(i));
  end

  assign fld_mask = low_mask << ctl.pos;
endmodule

// File: rtl/bfx_datapath.sv
module bfx_datapath
  import bfx_pkg::*;
#(
  parameter int LW = LANE_W
) (
  input  bfx_op_e       op,
  input  bfx_ctl_t      ctl,
  input  logic [LW-1:0] low_mask,
  input  logic [LW-1:0] fld_mask,
  input  logic [LW-1:0] dst,
  input  logic [LW-1:0] src,
  output logic [LW-1:0] lane_res
);
  logic [LW-1:0] ext_val;
  logic [LW-1:0] ins_val;
  logic          unused_len;

  assign ext_val = (dst >> ctl.pos) & low_mask;
  assign ins_val = (dst & ~fld_mask) | ((src << ctl.pos) & fld_mask);

  always_comb begin
    case (op)
      BFX_INSERT: lane_res = ins_val;
      default:    lane_res = ext_val;
    endcase
  end

  assign unused_len = ^ctl.len;
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
  import bfx_pkg::*;
#(
  parameter int VW    = VEC_W,
  parameter int LW    = LANE_W,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             op_insert,
  input  logic             use_reg,
  input  logic [IMM_W-1:0] imm_len,
  input  logic [IMM_W-1:0] imm_pos,
  input  logic [VW-1:0]    opa,
  input  logic [VW-1:0]    opb,
  output logic             res_valid,
  output logic [VW-1:0]    res_data
);
  localparam int CW = $clog2(LW);

  bfx_op_e       op_sel;
  bfx_ctl_t      ctl;
  logic [LW-1:0] low_mask;
  logic [LW-1:0] fld_mask;
  logic [LW-1:0] lane_res;
  logic          unused_hi;

  assign op_sel = op_insert ? BFX_INSERT : BFX_EXTRACT;

  bfx_ctl_sel #(
    .VW(VW), .LW(LW), .CW(CW), .IMM_W(IMM_W),
    .EXT_LEN_LSB(0), .EXT_POS_LSB(8),
    .INS_LEN_LSB(LW), .INS_POS_LSB(LW + 8)
  ) u_ctl (
    .op      (op_sel),
    .use_reg (use_reg),
    .imm_len (imm_len),
    .imm_pos (imm_pos),
    .opb     (opb),
    .ctl     (ctl)
  );

  bfx_mask_gen #(.LW(LW), .CW(CW)) u_mask (
    .ctl      (ctl),
    .low_mask (low_mask),
    .fld_mask (fld_mask)
  );

  bfx_datapath #(.LW(LW)) u_dp (
    .op       (op_sel),
    .ctl      (ctl),
    .low_mask (low_mask),
    .fld_mask (fld_mask),
    .dst      (opa[LW-1:0]),
    .src      (opb[LW-1:0]),
    .lane_res (lane_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_data <= {{(VW-LW){1'b0}}, lane_res};
    end
  end

  assign unused_hi = ^opa[VW-1:LW];
endmodule

// File: rtl/bfx_unit_chk.sv
module bfx_unit_chk #(
  parameter int VW    = 128,
  parameter int LW    = 64,
  parameter int IMM_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             op_insert,
  input logic             use_reg,
  input logic [IMM_W-1:0] imm_len,
  input logic             res_valid,
  input logic [VW-1:0]    res_data
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!res_valid && res_data == '0));

  a_r2_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);

  a_r9_upper_half_zero: assert property (@(posedge clk) disable iff (rst)
    res_data[VW-1:LW] == '0);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(res_data));

  // R3: a one-bit immediate extract leaves only bit 0 possibly set
  a_r3_single_bit_fill: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !op_insert && !use_reg && imm_len[5:0] == 6'd1)
      |=> res_data[LW-1:1] == '0);
endmodule

bind bfx_unit bfx_unit_chk #(.VW(VW), .LW(LW), .IMM_W(IMM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .op_insert (op_insert),
  .use_reg   (use_reg),
  .imm_len   (imm_len),
  .res_valid (res_valid),
  .res_data  (res_data)
);

// File: tb/sim_bfx_unit.sv
`timescale 1ns/1ps
module sim_bfx_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         op_insert = 1'b0;
  logic         use_reg = 1'b0;
  logic [7:0]   imm_len = '0;
  logic [7:0]   imm_pos = '0;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic         res_valid;
  logic [127:0] res_data;

  always #2.5 clk = ~clk;

  bfx_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .op_insert(op_insert),
    .use_reg(use_reg), .imm_len(imm_len), .imm_pos(imm_pos),
    .opa(opa), .opb(opb), .res_valid(res_valid), .res_data(res_data)
  );

  typedef struct {
    logic [127:0] exp;
    string        tag;
  } sb_item_t;

  sb_item_t     sb_q[$];
  int           n_checks = 0;
  int           n_fail   = 0;
  bit           done     = 1'b0;
  logic [127:0] last_exp = '0;

  function automatic logic [63:0] model(bit ins, logic [63:0] a, logic [63:0] b,
                                        int n, int p);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      if (ins) r[i] = (i >= p && i < p + n) ? b[i-p] : a[i];
      else     r[i] = (i < n && i + p < 64) ? a[i+p] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one request per call, expected value pushed to the scoreboard
  task automatic apply(bit ins, bit rg, logic [7:0] il, logic [7:0] ip,
                       logic [127:0] a, logic [127:0] b, string tag);
    int lc, pc, n;
    sb_item_t it;
    if (rg) begin
      lc = ins ? int'(b[69:64]) : int'(b[5:0]);
      pc = ins ? int'(b[77:72]) : int'(b[13:8]);
    end else begin
      lc = int'(il[5:0]);
      pc = int'(ip[5:0]);
    end
    n = (lc == 0) ? 64 : lc;
    it.exp = {64'h0, model(ins, a[63:0], b[63:0], n, pc)};
    it.tag = tag;
    sb_q.push_back(it);
    req_valid = 1'b1; op_insert = ins; use_reg = rg;
    imm_len = il; imm_pos = ip; opa = a; opb = b;
    @(negedge clk);
  endtask

  task automatic idle(int cycles);
    req_valid = 1'b0;
    opa = {4{32'hDEAD_BEEF}};
    opb = {4{32'h5A5A_C3C3}};
    repeat (cycles) @(negedge clk);
  endtask

  // monitor: compare each valid result against the scoreboard head
  always begin
    @(posedge clk);
    #1;
    if (!rst && res_valid) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R2: unexpected result actual %h expected none", res_data);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(it.tag, res_data, it.exp);
        last_exp = it.exp;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] a0, b0;
    a0 = {64'hFFFF_0000_FFFF_0000, 64'h1234_5678_9ABC_DEF0};
    b0 = {64'hAAAA_5555_AAAA_5555, 64'hFEDC_BA98_7654_3210};
    @(negedge clk);
    repeat (3) @(negedge clk);
    check("R1 reset valid", {127'h0, res_valid}, 128'h0);
    check("R1 reset data", res_data, 128'h0);
    rst = 1'b0;
    @(negedge clk);

    apply(0, 0, 8'd8,  8'd4,  a0, b0, "R3 extract imm 8@4");
    apply(0, 0, 8'd1,  8'd63, a0, b0, "R3 extract 1@63");
    apply(0, 0, 8'd20, 8'd50, a0, b0, "R3 extract past top");
    apply(1, 0, 8'd16, 8'd20, a0, b0, "R4 insert imm 16@20");
    apply(1, 0, 8'd3,  8'd0,  a0, b0, "R4 insert 3@0");
    apply(0, 0, 8'd0,  8'd0,  a0, b0, "R5 extract len0 full");
    apply(0, 0, 8'd0,  8'd8,  a0, b0, "R5 extract len0 @8");
    apply(1, 0, 8'd0,  8'd0,  a0, b0, "R5 insert len0 full");
    apply(0, 0, 8'hC8, 8'hC4, a0, b0, "R5 high code bits ignored");
    apply(0, 1, 8'd40, 8'd2,
          a0, {64'h0000_3F00_0000_2100, 64'hFFFF_0000_0000_030C},
          "R6 reg extract");
    apply(1, 1, 8'd5,  8'd7,
          a0, {64'h0000_0000_0000_320A, 64'h0000_0000_0000_03FF},
          "R7 reg insert");
    apply(1, 0, 8'd12, 8'd9,
          a0, {64'h0000_3F00_0000_2100, 64'h0000_0000_0000_0ABC},
          "R8 imm insert ignores opb fields");
    apply(1, 0, 8'd20, 8'd56, a0, b0, "R10 insert truncated");
    apply(0, 0, 8'd32, 8'd16, {64'hFFFF_FFFF_FFFF_FFFF, a0[63:0]}, b0,
          "R9 upper opa ignored");
    idle(3);
    check("R11 idle valid low", {127'h0, res_valid}, 128'h0);
    check("R11 idle hold", res_data, last_exp);

    for (int k = 0; k < 60; k++) begin
      apply(bit'($urandom % 2), bit'($urandom % 2), 8'($urandom), 8'($urandom),
            {$urandom, $urandom, $urandom, $urandom},
            {$urandom, $urandom, $urandom, $urandom}, "R2 back-to-back");
    end
    idle(4);
    check("R2 queue drained", 128'(sb_q.size()), 128'h0);
    check("R11 final hold", res_data, last_exp);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule